// File: doc/BRIEF.md
# PRBS Link Tester with Training

This block provides both ends of a bit-error-rate test over a serial link between two devices that share a reference clock. The transmit half waits idle until told to start. It then sends a burst of alignment words so the far end can frame the stream, and after that a continuous PRBS-31 pattern. Every word goes out as a ten-bit symbol: a two-bit header marks it as data or control, and the header always contains a transition. The symbols go to an external serializer.

The receive half takes ten-bit symbols from the external deserializer and looks for a run of alignment words. It then seeds a local PRBS-31 predictor from the first data bits it sees. From that point it compares every received bit against the prediction. It keeps live counts of compared bits and mismatched bits, so the error rate can be read at any time. When errors pile up inside a sliding block of words, the receiver gives up lock and raises a one-cycle request to retrain the link. A link-reset input clears both halves and the counters.

Top module: `prbs_link_tester`

## Requirements
- R1: After reset, and until `start` is sampled high, `tx_sym` carries the idle control symbol 10'h200 (header 2'b10, payload 8'h00).
- R2: The edge that samples `start` high in the idle or data state is followed by exactly TRAIN_LEN (default 128) alignment symbols 10'h27C (header 2'b10, payload 8'h7C), one per cycle, and then by data symbols. A new `start` during data restarts the training burst.
- R3: A data symbol has header bits [9:8] = 2'b01 and carries eight PRBS-31 bits (x^31 + x^28 + 1, each new bit = state[30] xor state[27], shifted in at bit 0) in payload bits [7:0], the earliest bit in bit 7. The generator restarts from PRBS_SEED at each start. The headers 2'b00 and 2'b11 are never sent.
- R4: `rx_trained` rises on the edge that samples the LOCK_RUN-th (default 16) consecutive alignment symbol, and not earlier.
- R5: After training, the first four data symbols (32 bits, enough to hold all 31 state bits) load the predictor without being compared. `rx_locked` rises on the edge that samples the fourth, and `rx_locked` implies `rx_trained`.
- R6: While locked, `bit_count` grows by 8 for every symbol received.
- R7: While locked, `err_count` grows by the number of payload bits that differ from the prediction. A symbol whose header is not 2'b01 adds 8. A wrong bit does not disturb the following predictions.
- R8: `err_count` saturates at its all-ones value instead of wrapping.
- R9: If the errors within one WIN_LEN-word window (default 1024) exceed WIN_MAX_ERR (default 64), lock is dropped on the edge that samples the offending symbol. A window total of exactly WIN_MAX_ERR keeps lock.
- R10: A lock drop raises `retrain_req` for exactly one cycle, while `rx_locked` is low. The receiver then hunts for alignment symbols again.
- R11: While not locked, neither counter changes, whatever is received.
- R12: `link_rst` high at an edge (or `rst_n` low) clears both counters and the training state, and returns the transmitter to the idle symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both halves |
| rst_n | input | 1 | Synchronous active-low reset |
| link_rst | input | 1 | Synchronous link reset: clears training state and counters |
| start | input | 1 | Begin (or restart) the training burst followed by PRBS data |
| tx_sym | output | 10 | Coded symbol toward the serializer |
| rx_sym | input | 10 | Coded symbol from the deserializer |
| rx_trained | output | 1 | Alignment run seen |
| rx_locked | output | 1 | Predictor seeded; bits being compared |
| retrain_req | output | 1 | One-cycle pulse when lock is dropped for too many errors |
| err_count | output | ERR_W | Saturating count of mismatched bits |
| bit_count | output | BIT_W | Count of compared bits |

## Verification
`tx_sym` is registered. A symbol decided at one edge is on the port until the next edge, and the first alignment symbol appears one edge after the edge that samples `start`. The scoreboard queues the expected symbols from that edge on and compares one at each falling edge. The receive path has no input register, so `rx_trained`, `rx_locked`, both counters and `retrain_req` all change on the same edge that samples the deciding symbol. Every receive check is therefore made 1 ns after that edge, with the edges counted from the return of the start task. Errors are injected by xoring a mask into the looped-back symbol for exactly one cycle. The resulting counter value is read 1 ns after the edge that consumed the corrupted symbol.

// File: rtl/prbs_link_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, symbol encodings, state types and PRBS-31 helpers
// for the link tester. Assumes eight payload bits per ten-bit symbol.
package prbs_link_pkg;

    localparam int DW         = 8;                          // payload bits per symbol
    localparam int SW         = DW + 2;                     // symbol width with header
    localparam int PRBS_LEN   = 31;                         // generator length
    localparam int TAP_A      = 30;                         // x^31 term
    localparam int TAP_B      = 27;                         // x^28 term
    localparam int SEED_WORDS = (PRBS_LEN + DW - 1) / DW;   // words to fill predictor
    localparam int EW         = $clog2(DW + 1);             // per-word error count width

    localparam logic [1:0]    HDR_DATA  = 2'b01;
    localparam logic [1:0]    HDR_CTRL  = 2'b10;
    localparam logic [DW-1:0] PAY_ALIGN = 8'h7C;
    localparam logic [DW-1:0] PAY_IDLE  = 8'h00;
    localparam logic [SW-1:0] SYM_ALIGN = {HDR_CTRL, PAY_ALIGN};
    localparam logic [SW-1:0] SYM_IDLE  = {HDR_CTRL, PAY_IDLE};

    typedef logic [PRBS_LEN-1:0] prbs_state_t;

    typedef enum logic [1:0] {TX_IDLE, TX_TRAIN, TX_DATA} tx_state_e;
    typedef enum logic [1:0] {RX_HUNT, RX_TRAINED, RX_SEED, RX_LOCKED} rx_state_e;

    // Next DW generator bits, earliest bit in the MSB.
    function automatic logic [DW-1:0] prbs_word(input prbs_state_t s);
        prbs_state_t   t;
        logic          b;
        logic [DW-1:0] w;
        t = s;
        w = '0;
        for (int i = 0; i < DW; i++) begin
            b         = t[TAP_A] ^ t[TAP_B];
            w[DW-1-i] = b;
            t         = {t[PRBS_LEN-2:0], b};
        end
        return w;
    endfunction

    // Generator state after DW steps.
    function automatic prbs_state_t prbs_adv(input prbs_state_t s);
        prbs_state_t t;
        logic        b;
        t = s;
        for (int i = 0; i < DW; i++) begin
            b = t[TAP_A] ^ t[TAP_B];
            t = {t[PRBS_LEN-2:0], b};
        end
        return t;
    endfunction

    // Number of set bits in a payload word.
    function automatic logic [EW-1:0] ones(input logic [DW-1:0] v);
        logic [EW-1:0] n;
        n = '0;
        for (int i = 0; i < DW; i++) begin
            n = n + EW'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/link_tx.sv
`timescale 1ns/1ps
// Transmit half: sends idle symbols until started, then TRAIN_LEN alignment
// symbols, then PRBS-31 data symbols. Output is registered. Assumes start is
// synchronous to clk.
module link_tx
    import prbs_link_pkg::*;
#(
    parameter int          TRAIN_LEN = 128,
    parameter prbs_state_t PRBS_SEED = 31'h1A5A1234
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_rst,
    input  logic          start,
    output logic [SW-1:0] tx_sym
);

    localparam int CW = $clog2(TRAIN_LEN) + 1;

    tx_state_e   st;
    logic [CW-1:0] cnt;
    prbs_state_t lfsr;

    // Sequencer: idle -> training burst -> PRBS data, with restart on start.
    always_ff @(posedge clk) begin
        if (!rst_n || link_rst) begin
            st     <= TX_IDLE;
            cnt    <= '0;
            lfsr   <= PRBS_SEED;
            tx_sym <= SYM_IDLE;
        end else begin
            case (st)
                TX_IDLE: begin
                    tx_sym <= SYM_IDLE;
                    if (start) begin
                        st   <= TX_TRAIN;
                        cnt  <= '0;
                        lfsr <= PRBS_SEED;
                    end
                end
                TX_TRAIN: begin
                    tx_sym <= SYM_ALIGN;
                    cnt    <= cnt + CW'(1);
                    if (cnt == CW'(TRAIN_LEN - 1)) begin
                        st <= TX_DATA;
                    end
                end
                TX_DATA: begin
                    tx_sym <= {HDR_DATA, prbs_word(lfsr)};
                    lfsr   <= prbs_adv(lfsr);
                    if (start) begin
                        st   <= TX_TRAIN;
                        cnt  <= '0;
                        lfsr <= PRBS_SEED;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_framer.sv
`timescale 1ns/1ps
// Receive framing: hunts for LOCK_RUN consecutive alignment symbols, then
// feeds SEED_WORDS data payloads into the predictor and enters the locked
// state. It leaves lock when the error monitor reports a drop. Assumes
// symbols are already word aligned by the deserializer.
module rx_framer
    import prbs_link_pkg::*;
#(
    parameter int LOCK_RUN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_rst,
    input  logic [SW-1:0] rx_sym,
    input  logic          drop,
    output logic          load,
    output logic          cmp,
    output logic          hdr_ok,
    output logic [DW-1:0] payload,
    output logic          trained,
    output logic          locked
);

    localparam int RW  = $clog2(LOCK_RUN) + 1;
    localparam int SCW = $clog2(SEED_WORDS) + 1;

    rx_state_e      st;
    logic [RW-1:0]  run;
    logic [SCW-1:0] scnt;
    logic           is_align;

    // Symbol decode and strobes for the predictor.
    always_comb begin
        is_align = (rx_sym == SYM_ALIGN);
        hdr_ok   = (rx_sym[SW-1 -: 2] == HDR_DATA);
        payload  = rx_sym[DW-1:0];
        load     = ((st == RX_TRAINED) || (st == RX_SEED)) && hdr_ok;
        cmp      = (st == RX_LOCKED);
        trained  = (st != RX_HUNT);
        locked   = (st == RX_LOCKED);
    end

    // Framing state machine: hunt, trained, seeding, locked.
    always_ff @(posedge clk) begin
        if (!rst_n || link_rst) begin
            st   <= RX_HUNT;
            run  <= '0;
            scnt <= '0;
        end else begin
            case (st)
                RX_HUNT: begin
                    if (is_align) begin
                        if (run == RW'(LOCK_RUN - 1)) begin
                            st  <= RX_TRAINED;
                            run <= '0;
                        end else begin
                            run <= run + RW'(1);
                        end
                    end else begin
                        run <= '0;
                    end
                end
                RX_TRAINED: begin
                    if (hdr_ok) begin
                        st   <= RX_SEED;
                        scnt <= SCW'(1);
                    end else if (!is_align) begin
                        st <= RX_HUNT;
                    end
                end
                RX_SEED: begin
                    if (hdr_ok) begin
                        if (scnt == SCW'(SEED_WORDS - 1)) begin
                            st <= RX_LOCKED;
                        end else begin
                            scnt <= scnt + SCW'(1);
                        end
                    end else begin
                        st <= RX_HUNT;
                    end
                end
                RX_LOCKED: begin
                    if (drop) begin
                        st <= RX_HUNT;
                    end
                end
                default: st <= RX_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/prbs_checker.sv
`timescale 1ns/1ps
// Local PRBS-31 predictor: shifts received payloads in while loading, then
// free-runs on its own prediction and reports the mismatching bits of each
// compared word. A symbol with a non-data header counts as DW errors.
module prbs_checker
    import prbs_link_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          cmp,
    input  logic          hdr_ok,
    input  logic [DW-1:0] payload,
    output logic [EW-1:0] word_errs
);

    prbs_state_t st;

    // Predictor state: seed from the line, then advance independently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (load) begin
            st <= {st[PRBS_LEN-DW-1:0], payload};
        end else if (cmp) begin
            st <= prbs_adv(st);
        end
    end

    // Bit errors of the word being compared this cycle.
    always_comb begin
        word_errs = '0;
        if (cmp) begin
            word_errs = hdr_ok ? ones(payload ^ prbs_word(st)) : EW'(DW);
        end
    end

endmodule

// File: rtl/err_monitor.sv
`timescale 1ns/1ps
// Error accounting: saturating error counter, compared-bit counter, and a
// WIN_LEN-word window that requests a lock drop when its error sum would
// exceed WIN_MAX_ERR. The window restarts whenever comparing stops.
module err_monitor
    import prbs_link_pkg::*;
#(
    parameter int ERR_W       = 32,
    parameter int BIT_W       = 48,
    parameter int WIN_LEN     = 1024,
    parameter int WIN_MAX_ERR = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_rst,
    input  logic             cmp,
    input  logic [EW-1:0]    word_errs,
    output logic             drop,
    output logic             retrain_req,
    output logic [ERR_W-1:0] err_count,
    output logic [BIT_W-1:0] bit_count
);

    localparam int WCW  = $clog2(WIN_LEN) + 1;
    localparam int SUMW = $clog2(WIN_MAX_ERR + DW + 1) + 1;
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    logic [WCW-1:0]  win_cnt;
    logic [SUMW-1:0] win_err;
    logic [SUMW-1:0] win_sum;
    logic [ERR_W:0]  err_ext;

    // Window total including this word, drop decision, widened error sum.
    always_comb begin
        win_sum = win_err + SUMW'(word_errs);
        drop    = cmp && (win_sum > SUMW'(WIN_MAX_ERR));
        err_ext = {1'b0, err_count} + (ERR_W + 1)'(word_errs);
    end

    // Counters, window bookkeeping and retrain pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || link_rst) begin
            err_count   <= '0;
            bit_count   <= '0;
            win_cnt     <= '0;
            win_err     <= '0;
            retrain_req <= 1'b0;
        end else begin
            retrain_req <= drop;
            if (cmp) begin
                bit_count <= bit_count + BIT_W'(DW);
                err_count <= err_ext[ERR_W] ? ERR_MAX : err_ext[ERR_W-1:0];
                if (drop || (win_cnt == WCW'(WIN_LEN - 1))) begin
                    win_cnt <= '0;
                    win_err <= '0;
                end else begin
                    win_cnt <= win_cnt + WCW'(1);
                    win_err <= win_sum;
                end
            end else begin
                win_cnt <= '0;
                win_err <= '0;
            end
        end
    end

endmodule

// File: rtl/prbs_link_tester.sv
`timescale 1ns/1ps
// Top: transmit sequencer plus receive framer, predictor and error monitor
// for a PRBS-31 link test. Assumes both halves run from one shared clock and
// that the deserializer presents whole, aligned symbols.
module prbs_link_tester
    import prbs_link_pkg::*;
#(
    parameter int          TRAIN_LEN   = 128,
    parameter int          LOCK_RUN    = 16,
    parameter int          WIN_LEN     = 1024,
    parameter int          WIN_MAX_ERR = 64,
    parameter int          ERR_W       = 32,
    parameter int          BIT_W       = 48,
    parameter prbs_state_t PRBS_SEED   = 31'h1A5A1234
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_rst,
    input  logic             start,
    output logic [SW-1:0]    tx_sym,
    input  logic [SW-1:0]    rx_sym,
    output logic             rx_trained,
    output logic             rx_locked,
    output logic             retrain_req,
    output logic [ERR_W-1:0] err_count,
    output logic [BIT_W-1:0] bit_count
);

    logic          load;
    logic          cmp;
    logic          hdr_ok;
    logic [DW-1:0] payload;
    logic [EW-1:0] word_errs;
    logic          drop;

    link_tx #(
        .TRAIN_LEN (TRAIN_LEN),
        .PRBS_SEED (PRBS_SEED)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_rst (link_rst),
        .start    (start),
        .tx_sym   (tx_sym)
    );

    rx_framer #(
        .LOCK_RUN (LOCK_RUN)
    ) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_rst (link_rst),
        .rx_sym   (rx_sym),
        .drop     (drop),
        .load     (load),
        .cmp      (cmp),
        .hdr_ok   (hdr_ok),
        .payload  (payload),
        .trained  (rx_trained),
        .locked   (rx_locked)
    );

    prbs_checker u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .cmp       (cmp),
        .hdr_ok    (hdr_ok),
        .payload   (payload),
        .word_errs (word_errs)
    );

    err_monitor #(
        .ERR_W       (ERR_W),
        .BIT_W       (BIT_W),
        .WIN_LEN     (WIN_LEN),
        .WIN_MAX_ERR (WIN_MAX_ERR)
    ) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_rst    (link_rst),
        .cmp         (cmp),
        .word_errs   (word_errs),
        .drop        (drop),
        .retrain_req (retrain_req),
        .err_count   (err_count),
        .bit_count   (bit_count)
    );

endmodule

// File: rtl/link_tester_props.sv
`timescale 1ns/1ps
// Checker: temporal properties on the top-level ports of the link tester.
module link_tester_props
    import prbs_link_pkg::*;
#(
    parameter int ERR_W = 32,
    parameter int BIT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_rst,
    input logic [SW-1:0]    tx_sym,
    input logic             rx_trained,
    input logic             rx_locked,
    input logic             retrain_req,
    input logic [ERR_W-1:0] err_count,
    input logic [BIT_W-1:0] bit_count
);

    // R3: only the data and control headers ever leave the transmitter
    a_r3_tx_header_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sym[SW-1 -: 2] == HDR_DATA) || (tx_sym[SW-1 -: 2] == HDR_CTRL));

    // R5: lock is only held once training has been seen
    a_r5_locked_implies_trained: assert property (@(posedge clk) disable iff (!rst_n)
        rx_locked |-> rx_trained);

    // R10: retrain request lasts a single cycle
    a_r10_retrain_single: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_req |=> !retrain_req);

    // R10: retrain request coincides with loss of lock
    a_r10_retrain_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_req |-> !rx_locked);

    // R8: error counter never goes down unless the link is reset
    a_r8_err_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !link_rst |=> (err_count >= $past(err_count)));

    // R6: bit counter holds or moves by exactly one word
    a_r6_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !link_rst |=> ((bit_count == $past(bit_count)) ||
                       (bit_count == $past(bit_count) + BIT_W'(DW))));

    // R11: nothing is counted while unlocked
    a_r11_hold_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_locked && !link_rst) |=> ($stable(err_count) && $stable(bit_count)));

endmodule

bind prbs_link_tester link_tester_props #(
    .ERR_W (ERR_W),
    .BIT_W (BIT_W)
) u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_rst    (link_rst),
    .tx_sym      (tx_sym),
    .rx_trained  (rx_trained),
    .rx_locked   (rx_locked),
    .retrain_req (retrain_req),
    .err_count   (err_count),
    .bit_count   (bit_count)
);

// File: tb/tb_prbs_link_tester.sv
`timescale 1ns/1ps
// Bench: loops tx_sym back to rx_sym through an error-injection mask. The
// start driver queues the expected transmit symbols and a falling-edge
// monitor compares them. Receive results are checked 1 ns after the edge
// on which they are due.
module tb_prbs_link_tester;

    localparam logic [30:0] SEED    = 31'h1A5A1234;
    localparam int          ERR_W   = 7;
    localparam int          BIT_W   = 48;
    localparam logic [9:0]  S_IDLE  = 10'h200;
    localparam logic [9:0]  S_ALIGN = 10'h27C;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             link_rst = 1'b0;
    logic             start = 1'b0;
    logic [9:0]       tx_sym;
    logic [9:0]       rx_sym;
    logic [9:0]       inj = '0;
    logic             rx_trained;
    logic             rx_locked;
    logic             retrain_req;
    logic [ERR_W-1:0] err_count;
    logic [BIT_W-1:0] bit_count;

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;
    logic [9:0] exp_q[$];
    int         sb_idx = 0;

    always #2.5 clk = ~clk;

    assign rx_sym = tx_sym ^ inj;

    prbs_link_tester #(
        .ERR_W     (ERR_W),
        .BIT_W     (BIT_W),
        .PRBS_SEED (SEED)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_rst    (link_rst),
        .start       (start),
        .tx_sym      (tx_sym),
        .rx_sym      (rx_sym),
        .rx_trained  (rx_trained),
        .rx_locked   (rx_locked),
        .retrain_req (retrain_req),
        .err_count   (err_count),
        .bit_count   (bit_count)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: raise start for one edge, then queue 128 align + 8 data symbols.
    task automatic start_link();
        logic [30:0] s;
        logic        b;
        logic [7:0]  w;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        @(posedge clk);
        #1;
        sb_idx = 0;
        for (int k = 0; k < 128; k++) exp_q.push_back(S_ALIGN);
        s = SEED;
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 8; i++) begin
                b        = s[30] ^ s[27];
                w[7 - i] = b;
                s        = {s[29:0], b};
            end
            exp_q.push_back({2'b01, w});
        end
    endtask

    // Monitor: compare one queued transmit symbol per cycle.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [9:0] e;
            e = exp_q.pop_front();
            chk((sb_idx < 128) ? "R2 align symbol" : "R3 data symbol", tx_sym, e);
            sb_idx++;
        end
    end

    // Follow one start through training and seeding; returns at edge 134 + 1 ns.
    task automatic wait_lock(input longint base_bits);
        repeat (15) @(posedge clk);
        #1 chk("R4 not trained after 15 aligns", rx_trained, 0);
        @(posedge clk);
        #1 chk("R4 trained at 16th align", rx_trained, 1);
        repeat (115) @(posedge clk);
        #1 chk("R5 not locked after 3 seed words", rx_locked, 0);
        @(posedge clk);
        #1 chk("R5 locked at 4th seed word", rx_locked, 1);
        chk("R5 no bits counted while seeding", bit_count, base_bits);
        @(posedge clk);
        #1 chk("R6 first compared word", bit_count, base_bits + 8);
    endtask

    task automatic inj_words(input logic [9:0] mask, input int n);
        inj = mask;
        repeat (n) @(posedge clk);
        #1 inj = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 idle symbol after reset", tx_sym, S_IDLE);
        chk("R12 trained clear", rx_trained, 0);
        chk("R12 locked clear", rx_locked, 0);
        chk("R12 err clear", err_count, 0);
        chk("R12 bits clear", bit_count, 0);
        repeat (5) @(posedge clk);
        #1 chk("R1 idle held without start", tx_sym, S_IDLE);

        // Phase A: first training and error counting
        start_link();
        wait_lock(0);
        inj_words(10'h001, 1);
        chk("R7 single bit error", err_count, 1);
        inj_words(10'h007, 1);
        chk("R7 three bit errors no propagation", err_count, 4);
        inj_words(10'h200, 1);
        chk("R7 bad header counts 8", err_count, 12);
        chk("R6 bits after four words", bit_count, 32);
        chk("R9 still locked under threshold", rx_locked, 1);

        // Phase B: exceed the window threshold
        inj_words(10'h200, 7);
        chk("R9 window total 68 drops lock", rx_locked, 0);
        chk("R7 errors at drop", err_count, 68);
        chk("R10 retrain pulse", retrain_req, 1);
        @(posedge clk);
        #1 chk("R10 retrain one cycle", retrain_req, 0);
        inj_words(10'h001, 1);
        chk("R11 no error counted unlocked", err_count, 68);
        chk("R11 no bits counted unlocked", bit_count, 88);
        chk("R10 back to hunting", rx_trained, 0);

        // Phase C: restart during data, exact threshold, saturation
        start_link();
        wait_lock(88);
        inj_words(10'h200, 8);
        chk("R9 window total of exactly 64 keeps lock", rx_locked, 1);
        chk("R8 saturates at all ones", err_count, 127);
        inj_words(10'h200, 1);
        chk("R9 drop after 72", rx_locked, 0);
        chk("R8 stays saturated", err_count, 127);
        chk("R10 retrain pulse again", retrain_req, 1);

        // Phase D: link reset
        link_rst = 1'b1;
        @(posedge clk);
        #1 link_rst = 1'b0;
        chk("R12 link reset clears errors", err_count, 0);
        chk("R12 link reset clears bits", bit_count, 0);
        chk("R12 link reset clears training", rx_trained, 0);
        chk("R12 link reset returns tx to idle", tx_sym, S_IDLE);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule